// File: doc/BRIEF.md
# Floating-Point Magnitude Min/Max Selector

This unit receives two IEEE-754 operands, either single precision or double precision, and forwards one of them unchanged. In magnitude mode it ignores the signs and compares the absolute values. It then returns the operand with the smaller or the larger absolute value, keeping that operand's own sign bit. In signed mode it uses the ordinary numeric order instead. Both modes share the same datapath and the same NaN handling. The result comes out of a single register stage.

A single-precision operand occupies the low 32 bits of each 64-bit operand port, and its upper bits are ignored. NaN encodings follow this convention: a NaN whose most significant fraction bit is 0 is quiet, and one whose most significant fraction bit is 1 is signalling.

The output stage has two states. `ST_IDLE` means no result is presented. `ST_SHOW` means a result is presented for this cycle. The stage moves from `ST_IDLE` to `ST_SHOW`, or stays in `ST_SHOW`, on any cycle with `valid_in` high. It moves from `ST_SHOW` to `ST_IDLE`, or stays in `ST_IDLE`, on any cycle with `valid_in` low.

Top module: `fmm_minmax_sel`

## Requirements
- R1: `valid_out` is high exactly one cycle after a cycle with `valid_in` high and is low otherwise; after reset `valid_out`, `result` and `invalid` are 0.
- R2: With `mode_mag`=1 and `op_max`=0, and with no NaN operand, the operand with the smaller absolute value is returned as its original bit pattern, sign included.
- R3: With `mode_mag`=1 and `op_max`=1, and with no NaN operand, the operand with the larger absolute value is returned as its original bit pattern.
- R4: In magnitude mode, when the two absolute values are equal, `opa` is returned (for example, -1.0 against +1.0 gives the `opa` bit pattern).
- R5: With `mode_mag`=0, `op_max`=0 returns the numerically smaller operand and `op_max`=1 returns the larger; equal values return `opa`.
- R6: In signed mode, -0 is ordered below +0. So signed min of (+0, -0) returns -0, and signed max of (-0, +0) returns +0.
- R7: With `fmt_dbl`=0, only bits [31:0] of each operand are used, bits [63:32] of `result` are 0, and values in the upper operand bits have no effect. With `fmt_dbl`=1, all 64 bits are used.
- R8: If exactly one operand is a NaN (exponent all ones, nonzero fraction), the other operand is returned unchanged, in every mode.
- R9: If both operands are NaN, the default quiet NaN is returned. This is 0x7FBFFFFF in single format (upper bits 0) and 0x7FF7FFFFFFFFFFFF in double format.
- R10: `invalid` is 1 with the result exactly when at least one operand is a signalling NaN, meaning the most significant fraction bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands and controls are valid this cycle |
| fmt_dbl | input | 1 | 1 selects double format, 0 selects single format |
| op_max | input | 1 | 1 selects maximum, 0 selects minimum |
| mode_mag | input | 1 | 1 compares magnitudes, 0 compares signed values |
| opa | input | 64 | First operand; favoured on ties |
| opb | input | 64 | Second operand |
| valid_out | output | 1 | Result and flag are valid |
| result | output | 64 | Selected operand or default quiet NaN |
| invalid | output | 1 | A signalling NaN was among the operands |

## Verification
The bench builds the block with its default parameters: 8 exponent and 23 fraction bits for single format, and 11 and 52 for double format. These are the standard encodings, so the bench can use well-known constants such as 1.0, -2.0, ±0, infinity and both NaN kinds in both formats. With these widths, single operands carry nonzero garbage in their upper 32 bits to show that those bits are ignored. Ties between signed zeros and between opposite-sign values of equal magnitude are also reachable. Inputs are applied back to back, so consecutive results must leave the pipeline without gaps or mixing.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } fmm_state_e;

    // relation flags produced by the comparator stage
    typedef struct packed {
        logic mag_le;    // |a| <= |b|
        logic mag_ge;    // |a| >= |b|
        logic sgn_le;    // a <= b, -0 below +0
        logic sgn_ge;    // a >= b, -0 below +0
    } fmm_rel_t;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
    parameter int EXP_S = 8,
    parameter int MAN_S = 23,
    parameter int EXP_D = 11,
    parameter int MAN_D = 52
) (
    input  logic [EXP_D+MAN_D:0]   op,
    input  logic                   fmt_dbl,
    output logic                   sign,
    output logic [EXP_D+MAN_D-1:0] mag,
    output logic                   is_nan,
    output logic                   is_snan,
    output logic [EXP_D+MAN_D:0]   canon
);
    localparam int W_S   = 1 + EXP_S + MAN_S;
    localparam int W_D   = 1 + EXP_D + MAN_D;
    localparam int PAD_W = W_D - W_S;

    logic exp_full;
    logic frac_nz;
    logic frac_top;

    always_comb begin
        if (fmt_dbl) begin
            sign     = op[W_D-1];
            mag      = op[W_D-2:0];
            exp_full = &op[MAN_D +: EXP_D];
            frac_nz  = |op[MAN_D-1:0];
            frac_top = op[MAN_D-1];
            canon    = op;
        end else begin
            sign     = op[W_S-1];
            mag      = {{PAD_W{1'b0}}, op[W_S-2:0]};
            exp_full = &op[MAN_S +: EXP_S];
            frac_nz  = |op[MAN_S-1:0];
            frac_top = op[MAN_S-1];
            canon    = {{PAD_W{1'b0}}, op[W_S-1:0]};
        end
        is_nan  = exp_full && frac_nz;
        is_snan = is_nan && frac_top;
    end

endmodule

// File: rtl/fmm_order.sv
module fmm_order
    import fmm_pkg::*;
#(
    parameter int MAG_W = 63
) (
    input  logic             sign_a,
    input  logic [MAG_W-1:0] mag_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_b,
    output fmm_rel_t         rel
);
    logic mag_lt;
    logic mag_eq;
    logic a_below;
    logic a_same;

    always_comb begin
        mag_lt = mag_a < mag_b;
        mag_eq = mag_a == mag_b;
        if (sign_a != sign_b) begin
            a_below = sign_a;
            a_same  = 1'b0;
        end else if (!sign_a) begin
            a_below = mag_lt;
            a_same  = mag_eq;
        end else begin
            a_below = !mag_lt && !mag_eq;
            a_same  = mag_eq;
        end
        rel.mag_le = mag_lt || mag_eq;
        rel.mag_ge = !mag_lt;
        rel.sgn_le = a_below || a_same;
        rel.sgn_ge = !a_below;
    end

endmodule

// File: rtl/fmm_pick.sv
module fmm_pick
    import fmm_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         mode_mag,
    input  logic         op_max,
    input  logic         nan_a,
    input  logic         nan_b,
    input  fmm_rel_t     rel,
    input  logic [W-1:0] canon_a,
    input  logic [W-1:0] canon_b,
    input  logic [W-1:0] dflt_nan,
    output logic [W-1:0] pick
);
    logic keep_a;

    always_comb begin
        unique case ({mode_mag, op_max})
            2'b00:   keep_a = rel.sgn_le;
            2'b01:   keep_a = rel.sgn_ge;
            2'b10:   keep_a = rel.mag_le;
            default: keep_a = rel.mag_ge;
        endcase
        if (nan_a && nan_b)
            pick = dflt_nan;
        else if (nan_a)
            pick = canon_b;
        else if (nan_b)
            pick = canon_a;
        else
            pick = keep_a ? canon_a : canon_b;
    end

endmodule

// File: rtl/fmm_minmax_sel.sv
module fmm_minmax_sel
    import fmm_pkg::*;
#(
    parameter int EXP_S = 8,
    parameter int MAN_S = 23,
    parameter int EXP_D = 11,
    parameter int MAN_D = 52
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_in,
    input  logic                   fmt_dbl,
    input  logic                   op_max,
    input  logic                   mode_mag,
    input  logic [EXP_D+MAN_D:0]   opa,
    input  logic [EXP_D+MAN_D:0]   opb,
    output logic                   valid_out,
    output logic [EXP_D+MAN_D:0]   result,
    output logic                   invalid
);
    localparam int W_S   = 1 + EXP_S + MAN_S;
    localparam int W_D   = 1 + EXP_D + MAN_D;
    localparam int MAG_W = W_D - 1;
    localparam logic [W_D-1:0] QNAN_S =
        {{(W_D-W_S){1'b0}}, 1'b0, {EXP_S{1'b1}}, 1'b0, {(MAN_S-1){1'b1}}};
    localparam logic [W_D-1:0] QNAN_D =
        {1'b0, {EXP_D{1'b1}}, 1'b0, {(MAN_D-1){1'b1}}};

    logic [W_D-1:0]   ops     [2];
    logic             sgn     [2];
    logic [MAG_W-1:0] mag     [2];
    logic             nan     [2];
    logic             snan    [2];
    logic [W_D-1:0]   canon   [2];

    assign ops[0] = opa;
    assign ops[1] = opb;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fmm_classify #(
            .EXP_S (EXP_S),
            .MAN_S (MAN_S),
            .EXP_D (EXP_D),
            .MAN_D (MAN_D)
        ) i_cls (
            .op      (ops[gi]),
            .fmt_dbl (fmt_dbl),
            .sign    (sgn[gi]),
            .mag     (mag[gi]),
            .is_nan  (nan[gi]),
            .is_snan (snan[gi]),
            .canon   (canon[gi])
        );
    end

    fmm_rel_t       rel;
    logic [W_D-1:0] pick;
    logic [W_D-1:0] dflt_nan;

    assign dflt_nan = fmt_dbl ? QNAN_D : QNAN_S;

    fmm_order #(.MAG_W(MAG_W)) i_order (
        .sign_a (sgn[0]),
        .mag_a  (mag[0]),
        .sign_b (sgn[1]),
        .mag_b  (mag[1]),
        .rel    (rel)
    );

    fmm_pick #(.W(W_D)) i_pick (
        .mode_mag (mode_mag),
        .op_max   (op_max),
        .nan_a    (nan[0]),
        .nan_b    (nan[1]),
        .rel      (rel),
        .canon_a  (canon[0]),
        .canon_b  (canon[1]),
        .dflt_nan (dflt_nan),
        .pick     (pick)
    );

    // output stage: state register
    fmm_state_e state_q;
    fmm_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = valid_in ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = valid_in ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output stage: data registers
    logic fmt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            invalid <= 1'b0;
            fmt_q   <= 1'b0;
        end else if (valid_in) begin
            result  <= pick;
            invalid <= snan[0] || snan[1];
            fmt_q   <= fmt_dbl;
        end
    end

    assign valid_out = (state_q == ST_SHOW);

    // R1: one-cycle strobe
    a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    a_r1_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    // R4: equal magnitudes favour the first operand
    a_r4_tie_first: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && mode_mag && !nan[0] && !nan[1] && mag[0] == mag[1])
        |=> result == $past(canon[0]));
    // R8: a lone NaN yields the other operand
    a_r8_lone_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && nan[0] && !nan[1]) |=> result == $past(canon[1]));
    // R9: two NaNs yield the default quiet NaN
    a_r9_both_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && nan[0] && nan[1])
        |=> result == ($past(fmt_dbl) ? QNAN_D : QNAN_S));
    // R10: flag tracks signalling inputs
    a_r10_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> invalid == $past(snan[0] || snan[1]));
    // R7: single results leave the upper half clear
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !fmt_q) |-> result[W_D-1:W_S] == '0);

endmodule

// File: tb/test_fmm_minmax_sel.sv
module test_fmm_minmax_sel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic        op_max = 1'b0;
    logic        mode_mag = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        valid_out;
    logic [63:0] result;
    logic        invalid;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmm_minmax_sel i_fmm_minmax_sel (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .fmt_dbl(fmt_dbl),
        .op_max(op_max), .mode_mag(mode_mag), .opa(opa), .opb(opb),
        .valid_out(valid_out), .result(result), .invalid(invalid)
    );

    typedef struct {
        logic [63:0] res;
        logic        inv;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    // independent reference: signed ordering via integer keys
    function automatic logic [64:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic dbl, input logic mx, input logic mg);
        logic [63:0] oa, ob, ma, mb;
        logic sa, sb, na, nb, sna, snb, pref_a;
        logic signed [65:0] ka, kb;
        logic [63:0] r;
        if (dbl) begin
            oa = a; ob = b;
            sa = a[63]; sb = b[63];
            ma = {1'b0, a[62:0]}; mb = {1'b0, b[62:0]};
            na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
            nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
            sna = na && a[51]; snb = nb && b[51];
        end else begin
            oa = {32'h0, a[31:0]}; ob = {32'h0, b[31:0]};
            sa = a[31]; sb = b[31];
            ma = {33'h0, a[30:0]}; mb = {33'h0, b[30:0]};
            na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
            nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
            sna = na && a[22]; snb = nb && b[22];
        end
        ka = sa ? (-$signed({2'b00, ma}) - 66'sd1) : $signed({2'b00, ma});
        kb = sb ? (-$signed({2'b00, mb}) - 66'sd1) : $signed({2'b00, mb});
        if (mg) pref_a = mx ? (ma >= mb) : (ma <= mb);
        else    pref_a = mx ? (ka >= kb) : (ka <= kb);
        if (na && nb)  r = dbl ? 64'h7FF7FFFFFFFFFFFF : 64'h000000007FBFFFFF;
        else if (na)   r = ob;
        else if (nb)   r = oa;
        else           r = pref_a ? oa : ob;
        return {sna || snb, r};
    endfunction

    task automatic send(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                        input logic mx, input logic mg, input string tag);
        logic [64:0] e;
        exp_t item;
        @(negedge clk);
        opa = a; opb = b; fmt_dbl = dbl; op_max = mx; mode_mag = mg;
        valid_in = 1'b1;
        e = model(a, b, dbl, mx, mg);
        item.res = e[63:0];
        item.inv = e[64];
        item.tag = tag;
        exp_q.push_back(item);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && valid_out) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL R1: unexpected valid_out actual=1 expected=0");
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                if (result !== it.res || invalid !== it.inv) begin
                    n_errors++;
                    $display("FAIL %s: actual res=%h inv=%b expected res=%h inv=%b",
                             it.tag, result, invalid, it.res, it.inv);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    localparam logic [63:0] GARB = 64'hDEADBEEF_00000000;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (valid_out !== 1'b0 || result !== 64'h0 || invalid !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: reset actual v=%b r=%h i=%b expected 0/0/0",
                     valid_out, result, invalid);
        end
        rst_n = 1'b1;
        // R2 magnitude min, sign kept
        send(GARB | 64'hC0000000, GARB | 64'h3F800000, 0, 0, 1, "R2");
        send(64'h00000000BF000000, 64'h000000003F800000, 0, 0, 1, "R2");
        // R3 magnitude max
        send(64'h000000003F800000, 64'h00000000C0000000, 0, 1, 1, "R3");
        send(64'h3FF0000000000000, 64'hC008000000000000, 1, 1, 1, "R3");
        // R4 ties
        send(64'h00000000BF800000, 64'h000000003F800000, 0, 0, 1, "R4");
        send(64'h3FF0000000000000, 64'hBFF0000000000000, 1, 1, 1, "R4");
        // R5 signed
        send(64'h000000003F800000, 64'h00000000C0000000, 0, 0, 0, "R5");
        send(64'h000000003F800000, 64'h00000000C0000000, 0, 1, 0, "R5");
        send(64'hC008000000000000, 64'hBFF0000000000000, 1, 0, 0, "R5");
        // R6 signed zeros
        send(64'h0000000000000000, 64'h0000000080000000, 0, 0, 0, "R6");
        send(64'h0000000080000000, 64'h0000000000000000, 0, 1, 0, "R6");
        send(64'h0000000000000000, 64'h8000000000000000, 1, 0, 0, "R6");
        // R7 garbage upper bits, infinity vs value
        send(64'hFFFFFFFF7F800000, 64'h12345678BF800000, 0, 1, 1, "R7");
        send(64'h0000000100000000, 64'h0000000000000001, 1, 0, 0, "R7");
        // R8 lone quiet NaN
        send(64'h000000007F800001, 64'h00000000C0000000, 0, 0, 1, "R8");
        send(64'h3FF0000000000000, 64'h7FF0000000000001, 1, 1, 0, "R8");
        // R9 two NaNs
        send(GARB | 64'h7F800001, 64'h00000000FFC00000, 0, 0, 1, "R9");
        send(64'h7FF0000000000001, 64'h7FF8000000000000, 1, 1, 0, "R9");
        // R10 signalling NaN with ordinary value
        send(64'h000000007FC00000, 64'h000000003F800000, 0, 1, 1, "R10");
        send(64'hC008000000000000, 64'hFFF8000000000001, 1, 0, 0, "R10");
        @(negedge clk);
        valid_in = 1'b0;
        // R1 strobe drops one cycle after input stops
        @(negedge clk);
        @(negedge clk);
        n_checks++;
        if (valid_out !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: idle actual=%b expected=0", valid_out);
        end
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R1: missing results actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule